// File: doc/BRIEF.md
# Dual-Clock FIFO with Mark and Retransmit

This block is a first-in first-out buffer whose producer and consumer run on unrelated clocks. Words enter on the write clock and leave on the read clock. Each side has an enable and a chip select, and both must be high for an operation to happen. The write and read pointers cross between the domains as Gray codes through two-stage synchronisers. The write side computes full and almost-full, and the read side computes empty and almost-empty. A mode input, sampled while master reset is held, selects one of two status timings. In standard timing the status pins report full and empty, and data reaches the output one read-clock edge after a read. In fall-through timing they report input-ready and output-ready, and the head word sits on the output before any read.

The almost-empty and almost-full thresholds come from a chain of flops on their own serial clock. Master reset loads both thresholds with one of four preset values chosen by a two-bit select. Serial shifting can then replace them. A mark pulse records the read position, and a later retransmit pulse rewinds the reader to it, so a consumer can replay a block of words. While a mark is held, the writer treats the marked words as still occupied. Partial reset empties the buffer and drops the mark, but keeps the thresholds and the timing mode. Master reset restores everything.

Top module: `retx_fifo`

## Requirements
- R1: After master reset in standard mode, rd_stat is 1 (empty), wr_stat is 0 (not full), pae is 1, paf is 0 and rd_data is 0.
- R2: In standard mode, words leave in the order they were written. rd_data takes the next word one rclk edge after an accepted read and holds its value otherwise.
- R3: Once DEPTH unreleased words are held, the FIFO is full. In standard mode wr_stat is 1, and further writes are dropped and never read back.
- R4: A read while the FIFO is empty has no effect: rd_data holds its value and the read position does not move.
- R5: A write needs wr_en and wr_cs both high at a wclk edge, and a read needs rd_en and rd_cs both high at an rclk edge. Any other combination is ignored.
- R6: In fall-through mode, rd_stat is 1 exactly when a word is available, and rd_data shows that head word without a read. wr_stat is 1 exactly when the FIFO is not full.
- R7: pae is 1 when the number of words visible to the reader is at most the almost-empty offset.
- R8: paf is 1 when the occupied count seen by the writer is at least DEPTH minus the almost-full offset.
- R9: At master reset, preset_sel values 0, 1, 2 and 3 load both offsets with 7, 31, 63 and 127, each limited to DEPTH-1.
- R10: Each sclk edge with sen high shifts sdi into a chain of 2*AW bits, MSB first. The first AW bits become the almost-empty offset and the next AW bits the almost-full offset. sdo is the top bit of the chain, which after a full load is the almost-empty offset's MSB.
- R11: A mark pulse records the current read position. A later retransmit pulse returns the reader to it, so the words from that position are delivered again in order.
- R12: While a mark is held, the words from the marked position onward still count as occupied for full and paf.
- R13: Partial reset empties the FIFO and clears the mark, but keeps the serially loaded offsets and the timing mode.
- R14: Master reset restores the preset offsets, clears the mark and samples fwft_sel again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| sclk | input | 1 | Serial offset clock |
| mrst_n | input | 1 | Master reset, active low, asynchronous |
| prst_n | input | 1 | Partial reset, active low, asynchronous |
| fwft_sel | input | 1 | Timing mode, sampled during master reset (1 = fall-through) |
| preset_sel | input | 2 | Offset preset choice, sampled during master reset |
| wr_en | input | 1 | Write enable |
| wr_cs | input | 1 | Write chip select |
| wdata | input | DW | Write data |
| rd_en | input | 1 | Read enable |
| rd_cs | input | 1 | Read chip select |
| mark | input | 1 | Record read position (rclk domain) |
| retx | input | 1 | Return to recorded read position (rclk domain) |
| sdi | input | 1 | Serial offset data |
| sen | input | 1 | Serial shift enable |
| rd_data | output | DW | Read data |
| wr_stat | output | 1 | Full (standard) or input-ready (fall-through) |
| rd_stat | output | 1 | Empty (standard) or output-ready (fall-through) |
| paf | output | 1 | Almost full |
| pae | output | 1 | Almost empty |
| sdo | output | 1 | Serial chain output |

## Verification
The bench fills the buffer to exactly DEPTH and pushes extra words into it. A design that overwrote data while full would read those extra words back. It also reads past empty, where a design that let the pointer slip would replay stale data or change rd_data. Writes and reads with the chip select low carry distinctive data that must never reach the output. The bench places a mark, reads past it, then refills: a writer that freed the marked words would show full late and corrupt the data that the retransmit replays. Thresholds are checked on both sides of each boundary after a serial load, after a partial reset and after a master reset with another preset. Offsets that the partial reset wiped, or the wrong shift order, would move pae off its expected count.

// File: rtl/retx_fifo_pkg.sv
package retx_fifo_pkg;

  // Preset threshold for a select code, limited to the largest usable offset.
  function automatic int preset_offset(input logic [1:0] sel, input int depth);
    int v;
    case (sel)
      2'd0:    v = 7;
      2'd1:    v = 31;
      2'd2:    v = 63;
      default: v = 127;
    endcase
    if (v > depth - 1) v = depth - 1;
    return v;
  endfunction

endpackage

// File: rtl/retx_fifo_rst_sync.sv
module retx_fifo_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [1:0] sh_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= {sh_q[0], 1'b1};
  end

  assign rst_n = sh_q[1];
endmodule

// File: rtl/retx_fifo_gray_sync.sv
module retx_fifo_gray_sync #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] gray_in,
  output logic [W-1:0] bin_out
);
  logic [W-1:0] s1_q, s2_q;

  function automatic logic [W-1:0] g2b(input logic [W-1:0] g);
    logic [W-1:0] b;
    b[W-1] = g[W-1];
    for (int i = W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= gray_in;
      s2_q <= s1_q;
    end
  end

  assign bin_out = g2b(s2_q);
endmodule

// File: rtl/retx_fifo_offsets.sv
module retx_fifo_offsets #(
  parameter int AW    = 4,
  parameter int DEPTH = 16
) (
  input  logic          sclk,
  input  logic          s_mrst_n,
  input  logic [1:0]    preset_sel,
  input  logic          sdi,
  input  logic          sen,
  output logic [AW-1:0] ae_off,
  output logic [AW-1:0] af_off,
  output logic          sdo
);
  localparam int CW = 2 * AW;

  logic [CW-1:0] chain_q, chain_d;
  logic [AW-1:0] preset;

  // Chain is a settings register: loaded from the preset while master reset
  // is held, shifted MSB first when enabled, never touched by partial reset.
  always_comb begin
    preset  = AW'(retx_fifo_pkg::preset_offset(preset_sel, DEPTH));
    chain_d = chain_q;
    if (!s_mrst_n)  chain_d = {preset, preset};
    else if (sen)   chain_d = {chain_q[CW-2:0], sdi};
  end

  always_ff @(posedge sclk) chain_q <= chain_d;

  assign ae_off = chain_q[CW-1:AW];
  assign af_off = chain_q[AW-1:0];
  assign sdo    = chain_q[CW-1];
endmodule

// File: rtl/retx_fifo.sv
module retx_fifo #(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          sclk,
  input  logic          mrst_n,
  input  logic          prst_n,
  input  logic          fwft_sel,
  input  logic [1:0]    preset_sel,
  input  logic          wr_en,
  input  logic          wr_cs,
  input  logic [DW-1:0] wdata,
  input  logic          rd_en,
  input  logic          rd_cs,
  input  logic          mark,
  input  logic          retx,
  input  logic          sdi,
  input  logic          sen,
  output logic [DW-1:0] rd_data,
  output logic          wr_stat,
  output logic          rd_stat,
  output logic          paf,
  output logic          pae,
  output logic          sdo
);
  localparam int DEPTH = 1 << AW;
  localparam int PW    = AW + 1;

  logic          any_rst_n;
  logic          w_rst_n, w_mrst_n, r_rst_n, r_mrst_n, s_mrst_n;
  logic [AW-1:0] ae_off, af_off;
  logic [DW-1:0] mem [DEPTH];

  assign any_rst_n = mrst_n & prst_n;

  retx_fifo_rst_sync u_wrs  (.clk(wclk), .arst_n(any_rst_n), .rst_n(w_rst_n));
  retx_fifo_rst_sync u_wmrs (.clk(wclk), .arst_n(mrst_n),    .rst_n(w_mrst_n));
  retx_fifo_rst_sync u_rrs  (.clk(rclk), .arst_n(any_rst_n), .rst_n(r_rst_n));
  retx_fifo_rst_sync u_rmrs (.clk(rclk), .arst_n(mrst_n),    .rst_n(r_mrst_n));
  retx_fifo_rst_sync u_smrs (.clk(sclk), .arst_n(mrst_n),    .rst_n(s_mrst_n));

  retx_fifo_offsets #(.AW(AW), .DEPTH(DEPTH)) u_offs (
    .sclk(sclk), .s_mrst_n(s_mrst_n), .preset_sel(preset_sel),
    .sdi(sdi), .sen(sen), .ae_off(ae_off), .af_off(af_off), .sdo(sdo)
  );

  // ---------------- write domain ----------------
  logic [PW-1:0] wbin, wbin_d, wgray_q, rel_gray_q, rel_bin_w, wcount;
  logic          wfull, push, fwft_w;

  retx_fifo_gray_sync #(.W(PW)) u_rel_sync (
    .clk(wclk), .rst_n(w_rst_n), .gray_in(rel_gray_q), .bin_out(rel_bin_w)
  );

  always_comb begin
    wcount = wbin - rel_bin_w;
    wfull  = wcount[AW];
    push   = wr_en & wr_cs & ~wfull;
    wbin_d = wbin + PW'(push);
  end

  always_ff @(posedge wclk or negedge w_rst_n) begin
    if (!w_rst_n) begin
      wbin    <= '0;
      wgray_q <= '0;
    end else begin
      wbin    <= wbin_d;
      wgray_q <= wbin_d ^ (wbin_d >> 1);
    end
  end

  always_ff @(posedge wclk) if (push) mem[wbin[AW-1:0]] <= wdata;
  always_ff @(posedge wclk) if (!w_mrst_n) fwft_w <= fwft_sel;

  assign paf     = wcount >= (PW'(DEPTH) - {1'b0, af_off});
  assign wr_stat = fwft_w ? ~wfull : wfull;

  // ---------------- read domain ----------------
  logic [PW-1:0] rbin, rbin_d, wbin_r, rcount, mark_ptr, mark_d;
  logic [PW-1:0] rel_bin, rel_d, rel_tgt;
  logic          rempty, pop, retx_ok, mark_set, mark_set_d, fwft_r;
  logic [DW-1:0] dout_q, dout_d;

  retx_fifo_gray_sync #(.W(PW)) u_wr_sync (
    .clk(rclk), .rst_n(r_rst_n), .gray_in(wgray_q), .bin_out(wbin_r)
  );

  always_comb begin
    rempty     = (rbin == wbin_r);
    rcount     = wbin_r - rbin;
    retx_ok    = retx & mark_set;
    pop        = rd_en & rd_cs & ~rempty & ~retx_ok;
    rbin_d     = rbin;
    if (retx_ok)  rbin_d = mark_ptr;
    else if (pop) rbin_d = rbin + PW'(1);
    mark_d     = mark ? rbin : mark_ptr;
    mark_set_d = mark_set | mark;
    // Released pointer walks one step per cycle so its Gray code changes one bit.
    rel_tgt    = mark_set ? mark_ptr : rbin;
    rel_d      = (rel_bin != rel_tgt) ? rel_bin + PW'(1) : rel_bin;
    dout_d     = pop ? mem[rbin[AW-1:0]] : dout_q;
  end

  always_ff @(posedge rclk or negedge r_rst_n) begin
    if (!r_rst_n) begin
      rbin       <= '0;
      mark_ptr   <= '0;
      mark_set   <= 1'b0;
      rel_bin    <= '0;
      rel_gray_q <= '0;
      dout_q     <= '0;
    end else begin
      rbin       <= rbin_d;
      mark_ptr   <= mark_d;
      mark_set   <= mark_set_d;
      rel_bin    <= rel_d;
      rel_gray_q <= rel_d ^ (rel_d >> 1);
      dout_q     <= dout_d;
    end
  end

  always_ff @(posedge rclk) if (!r_mrst_n) fwft_r <= fwft_sel;

  assign pae     = rcount <= {1'b0, ae_off};
  assign rd_stat = fwft_r ? ~rempty : rempty;
  assign rd_data = fwft_r ? mem[rbin[AW-1:0]] : dout_q;
endmodule

// File: rtl/retx_fifo_chk.sv
module retx_fifo_chk #(
  parameter int AW = 4
) (
  input logic        wclk,
  input logic        rclk,
  input logic        w_rst_n,
  input logic        r_rst_n,
  input logic        wr_en,
  input logic        wr_cs,
  input logic        rd_en,
  input logic        rd_cs,
  input logic        wfull,
  input logic        rempty,
  input logic        retx_ok,
  input logic        paf,
  input logic        pae,
  input logic [AW:0] wbin,
  input logic [AW:0] rbin,
  input logic [AW:0] mark_ptr,
  input logic [AW:0] wcount
);
  localparam int DEPTH = 1 << AW;

  // R3
  full_write_drop_chk: assert property (@(posedge wclk) disable iff (!w_rst_n)
    (wfull && wr_en && wr_cs) |=> $stable(wbin));

  // R3
  no_overflow_chk: assert property (@(posedge wclk) disable iff (!w_rst_n)
    wcount <= (AW+1)'(DEPTH));

  // R4
  empty_read_drop_chk: assert property (@(posedge rclk) disable iff (!r_rst_n)
    (rempty && rd_en && rd_cs && !retx_ok) |=> $stable(rbin));

  // R8
  full_means_paf_chk: assert property (@(posedge wclk) disable iff (!w_rst_n)
    wfull |-> paf);

  // R7
  empty_means_pae_chk: assert property (@(posedge rclk) disable iff (!r_rst_n)
    rempty |-> pae);

  // R11
  retx_restore_chk: assert property (@(posedge rclk) disable iff (!r_rst_n)
    retx_ok |=> (rbin == $past(mark_ptr)));
endmodule

bind retx_fifo retx_fifo_chk #(.AW(AW)) u_chk (
  .wclk(wclk), .rclk(rclk), .w_rst_n(w_rst_n), .r_rst_n(r_rst_n),
  .wr_en(wr_en), .wr_cs(wr_cs), .rd_en(rd_en), .rd_cs(rd_cs),
  .wfull(wfull), .rempty(rempty), .retx_ok(retx_ok), .paf(paf), .pae(pae),
  .wbin(wbin), .rbin(rbin), .mark_ptr(mark_ptr), .wcount(wcount)
);

// File: tb/retx_fifo_test.sv
`timescale 1ns/100ps
module retx_fifo_test;
  localparam int DW = 8, AW = 4, DEPTH = 16;

  logic wclk = 1'b0, rclk = 1'b0, sclk = 1'b0;
  logic mrst_n, prst_n, fwft_sel, wr_en, wr_cs, rd_en, rd_cs, mark, retx, sdi, sen;
  logic [1:0] preset_sel;
  logic [DW-1:0] wdata, rd_data;
  logic wr_stat, rd_stat, paf, pae, sdo;

  always #2 wclk = ~wclk;
  initial begin #1; forever #2 rclk = ~rclk; end
  initial begin #3; forever #2 sclk = ~sclk; end

  retx_fifo #(.DW(DW), .AW(AW)) uut (
    .wclk(wclk), .rclk(rclk), .sclk(sclk), .mrst_n(mrst_n), .prst_n(prst_n),
    .fwft_sel(fwft_sel), .preset_sel(preset_sel), .wr_en(wr_en), .wr_cs(wr_cs),
    .wdata(wdata), .rd_en(rd_en), .rd_cs(rd_cs), .mark(mark), .retx(retx),
    .sdi(sdi), .sen(sen), .rd_data(rd_data), .wr_stat(wr_stat), .rd_stat(rd_stat),
    .paf(paf), .pae(pae), .sdo(sdo)
  );

  // Behavioural reference: absolute word indices into a plain array.
  int mm [0:511];
  int wr_n, rd_idx, mark_idx, ae, af, dstd;
  bit marked, fw;
  int nchk = 0, nbad = 0;

  task automatic check(string req, int act, int exp);
    nchk++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int released();
    return marked ? mark_idx : rd_idx;
  endfunction

  task automatic chk_w(string req);
    int c;
    c = wr_n - released();
    check(req, int'(wr_stat), fw ? int'(c < DEPTH) : int'(c == DEPTH));
    check(req, int'(paf), int'(c >= DEPTH - af));
  endtask

  task automatic chk_r(string req);
    int c;
    c = wr_n - rd_idx;
    check(req, int'(rd_stat), fw ? int'(c > 0) : int'(c == 0));
    check(req, int'(pae), int'(c <= ae));
    if (!fw)        check(req, int'(rd_data), dstd);
    else if (c > 0) check(req, int'(rd_data), mm[rd_idx]);
  endtask

  task automatic wr(int d, bit cs, string req);
    @(negedge wclk); wr_en = 1'b1; wr_cs = cs; wdata = DW'(d);
    @(negedge wclk); wr_en = 1'b0;
    if (cs && (wr_n - released()) < DEPTH) begin mm[wr_n] = d; wr_n++; end
    chk_w(req);
  endtask

  task automatic rd(bit cs, string req);
    @(negedge rclk); rd_en = 1'b1; rd_cs = cs;
    @(negedge rclk); rd_en = 1'b0;
    if (cs && rd_idx < wr_n) begin dstd = mm[rd_idx]; rd_idx++; end
    chk_r(req);
  endtask

  task automatic settle_chk(string req);
    repeat (24) @(posedge wclk);
    @(negedge wclk); chk_w(req);
    @(negedge rclk); chk_r(req);
  endtask

  function automatic int preset_of(int sel);
    int p;
    p = (sel == 0) ? 7 : (sel == 1) ? 31 : (sel == 2) ? 63 : 127;
    return (p > DEPTH - 1) ? DEPTH - 1 : p;
  endfunction

  task automatic do_mreset(bit f, int sel);
    @(negedge wclk); mrst_n = 1'b0; fwft_sel = f; preset_sel = 2'(sel);
    repeat (4) @(negedge wclk);
    mrst_n = 1'b1;
    wr_n = 0; rd_idx = 0; mark_idx = 0; marked = 0; dstd = 0;
    fw = f; ae = preset_of(sel); af = preset_of(sel);
  endtask

  task automatic do_preset_clear();
    @(negedge wclk); prst_n = 1'b0;
    repeat (4) @(negedge wclk);
    prst_n = 1'b1;
    wr_n = 0; rd_idx = 0; mark_idx = 0; marked = 0; dstd = 0;
  endtask

  task automatic sload(int a, int f);
    logic [2*AW-1:0] v;
    v = {AW'(a), AW'(f)};
    for (int i = 2*AW - 1; i >= 0; i--) begin
      @(negedge sclk); sen = 1'b1; sdi = v[i];
    end
    @(negedge sclk); sen = 1'b0;
    ae = a; af = f;
    check("R10", int'(sdo), (a >> (AW-1)) & 1);
  endtask

  task automatic do_mark();
    @(negedge rclk); mark = 1'b1;
    @(negedge rclk); mark = 1'b0;
    mark_idx = rd_idx; marked = 1;
  endtask

  task automatic do_retx();
    @(negedge rclk); retx = 1'b1;
    @(negedge rclk); retx = 1'b0;
    if (marked) rd_idx = mark_idx;
    chk_r("R11");
  endtask

  initial begin
    #800000;
    nchk++; nbad++;
    $display("FAIL R2 watchdog: actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nbad);
    $finish;
  end

  initial begin
    mrst_n = 1'b0; prst_n = 1'b1; fwft_sel = 1'b0; preset_sel = 2'd0;
    wr_en = 1'b0; wr_cs = 1'b0; wdata = '0; rd_en = 1'b0; rd_cs = 1'b0;
    mark = 1'b0; retx = 1'b0; sdi = 1'b0; sen = 1'b0;

    // R1 reset state, standard mode, preset 7 (R9)
    do_mreset(1'b0, 0);
    settle_chk("R1");
    check("R1", int'(rd_stat), 1); check("R1", int'(wr_stat), 0);
    check("R1", int'(pae), 1);     check("R1", int'(paf), 0);
    check("R1", int'(rd_data), 0);

    // R8 threshold crossing on the write side, R5 dropped write
    for (int i = 0; i < 10; i++) wr(8'h10 + i, 1'b1, "R8");
    wr(8'hEE, 1'b0, "R5");
    settle_chk("R7");

    // R2 ordered reads, R5 dropped read
    for (int i = 0; i < 4; i++) rd(1'b1, "R2");
    rd(1'b0, "R5");
    settle_chk("R7");

    // R3 fill to full, extra writes dropped
    for (int i = 0; i < 10; i++) wr(8'h30 + i, 1'b1, "R3");
    check("R3", int'(wr_stat), 1);
    wr(8'hDD, 1'b1, "R3"); wr(8'hDD, 1'b1, "R3");
    settle_chk("R3");
    for (int i = 0; i < 16; i++) rd(1'b1, "R2");
    rd(1'b1, "R4"); rd(1'b1, "R4");
    settle_chk("R4");

    // R10 serial load: almost-empty 9, almost-full 5
    sload(9, 5);
    settle_chk("R10");
    for (int i = 0; i < 9; i++) wr(8'h50 + i, 1'b1, "R8");
    settle_chk("R7");
    check("R7", int'(pae), 1);
    wr(8'h59, 1'b1, "R8");
    settle_chk("R7");
    check("R7", int'(pae), 0);

    // R13 partial reset keeps loaded offsets
    do_preset_clear();
    settle_chk("R13");
    check("R13", int'(rd_stat), 1);
    for (int i = 0; i < 9; i++) wr(8'h60 + i, 1'b1, "R13");
    settle_chk("R13");
    check("R13", int'(pae), 1);
    wr(8'h69, 1'b1, "R8"); wr(8'h6A, 1'b1, "R8");
    settle_chk("R8");
    check("R8", int'(paf), 1);

    // R12 mark holds space, R11 retransmit replays
    rd(1'b1, "R2"); rd(1'b1, "R2");
    settle_chk("R11");
    do_mark();
    for (int i = 0; i < 3; i++) rd(1'b1, "R11");
    settle_chk("R12");
    for (int i = 0; i < 8; i++) wr(8'h70 + i, 1'b1, "R12");
    check("R12", int'(wr_stat), 1);
    settle_chk("R12");
    do_retx();
    for (int i = 0; i < 16; i++) rd(1'b1, "R11");
    rd(1'b1, "R4");
    settle_chk("R11");

    // R14 master reset to fall-through with preset 1 (limited to 15)
    do_mreset(1'b1, 1);
    settle_chk("R14");
    check("R6", int'(rd_stat), 0); check("R6", int'(wr_stat), 1);
    check("R14", int'(pae), 1);    check("R14", int'(paf), 0);
    wr(8'hA5, 1'b1, "R9");
    check("R9", int'(paf), 1);
    settle_chk("R6");
    check("R6", int'(rd_data), 8'hA5);
    check("R6", int'(rd_stat), 1);
    for (int i = 0; i < 4; i++) wr(8'hB0 + i, 1'b1, "R6");
    settle_chk("R6");
    for (int i = 0; i < 5; i++) rd(1'b1, "R6");
    settle_chk("R6");
    check("R6", int'(rd_stat), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nbad);
    $finish;
  end
endmodule